// File: doc/BRIEF.md
# Random-Interval Traffic Producer

This block is a traffic source and sink for profiling a streaming network. Its producer side keeps a counter that is reloaded from a small table of precomputed inter-arrival values. Each time that counter overflows, the producer writes one word into a producer FIFO. The network drains that FIFO through a show-ahead read port. Because the table values are drawn offline from an exponential distribution, the stream of words imitates Poisson arrivals at a chosen rate, not a fixed-rate feed.

The consumer side mirrors this. The network writes into a consumer FIFO. A second counter, driven by its own interval table, removes one word at each of its overflows. Both sides count accepted FIFO writes, so link utilization can be read as writes per elapsed cycle. The producer also counts the cycles it spent blocked on a full FIFO. Each FIFO has an almost-full flag with a programmable margin, used to profile near-full occupancy. A one-cycle `start` pulse begins a run. It flushes both FIFOs, clears the statistics and latches a transfer size in bytes, after which the producer stops on its own.

Top module: `poisson_traffic_src`

## Requirements
- R1: While reset is held, and after it until the first `start`, no word is produced or consumed. `prod_busy`, `net_rd_valid`, `cons_valid` and all three statistics counters are zero, and `net_wr_ready` is high.
- R2: On the `start` edge the producer counter loads table entry 0, where entry i is bits [i*CNT_W +: CNT_W] of `P_TABLE`. At each overflow it reloads the next entry, wrapping after entry ROM_DEPTH-1. An entry of value L places the next event 2^CNT_W - L cycles after the edge that loaded it.
- R3: Each producer event writes one word into the producer FIFO. The words of a run are the sequence numbers 0, 1, 2 and so on. The head word is shown on `net_rd_data` while `net_rd_valid` is high, and `net_rd_en` removes it.
- R4: The producer stops after ceil(`xfer_bytes`/(DATA_W/8)) words and drops `prod_busy`. A transfer size of zero produces nothing.
- R5: If an event finds the producer FIFO full, the word is held and the interval counter pauses. `stall_count` rises by one in every cycle the word waits on a full FIFO. The word is written once space appears, and no word is lost.
- R6: At each consumer overflow (same timing rule as R2, using `C_TABLE`), one word is removed from the consumer FIFO. It appears on `cons_data` with `cons_valid` high for one cycle after that edge. If the FIFO is empty, the read is held and its counter pauses until a word is present.
- R7: `net_wr_ready` is low while the consumer FIFO holds its full depth of FIFO_BYTES/(DATA_W/8) words. A write offered then, or on a `start` edge, is ignored.
- R8: `prod_wr_count` and `cons_wr_count` count the accepted writes into the producer and consumer FIFOs. Each rises by at most one per cycle and both clear on `start`.
- R9: `prod_af` (`cons_af`) is high exactly when the FIFO's word count plus `af_margin` is at least the FIFO depth.
- R10: A `start` pulse empties both FIFOs and restarts both tables at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for network and modules |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse beginning a run |
| xfer_bytes | input | XFER_W | Bytes to produce, latched on `start` |
| af_margin | input | LVL_W | Almost-full margin in words |
| net_rd_en | input | 1 | Network removes the producer FIFO head |
| net_rd_data | output | DATA_W | Producer FIFO head word |
| net_rd_valid | output | 1 | Producer FIFO not empty |
| net_wr_en | input | 1 | Network offers a word to the consumer FIFO |
| net_wr_data | input | DATA_W | Word offered to the consumer FIFO |
| net_wr_ready | output | 1 | Consumer FIFO has room |
| cons_data | output | DATA_W | Last word taken by the consumer |
| cons_valid | output | 1 | Consumer took a word on the previous edge |
| prod_busy | output | 1 | Producer still has bytes to send |
| prod_af | output | 1 | Producer FIFO almost full |
| cons_af | output | 1 | Consumer FIFO almost full |
| prod_wr_count | output | STAT_W | Accepted producer FIFO writes |
| cons_wr_count | output | STAT_W | Accepted consumer FIFO writes |
| stall_count | output | STAT_W | Cycles a due word waited on a full FIFO |

## Verification
The producer runs with a table of unequal intervals: 4, 2, 6 and 1 cycles. The write count is sampled one cycle before and on each expected event edge, and across the table wrap, which separates an off-by-one reload or a wrong table order from correct timing. Transfer sizes that are exact, rounded up and zero separate the stop rule from the word count. A run with no draining fills the FIFO, and the exact stall total before and after one pop separates hold-and-retry from dropping or double-writing a word. The consumer first meets an empty FIFO and then a flood of ten writes, which exercises the held read, the paused counter and the ignored write on a full FIFO.

// File: rtl/poisson_traffic_src.sv
`timescale 1ns/1ps
module poisson_traffic_src #(
  parameter int DATA_W     = 32,
  parameter int FIFO_BYTES = 512,
  parameter int ROM_DEPTH  = 16,
  parameter int CNT_W      = 16,
  parameter int XFER_W     = 20,
  parameter int STAT_W     = 32,
  parameter logic [ROM_DEPTH*CNT_W-1:0] P_TABLE =
    256'hFFF8_FFE4_FFF0_FF9A_FFFC_FFD2_FFF9_FFEE_FFB0_FFFE_FFDD_FFF6_FFC1_FFFA_FFE8_FFF3,
  parameter logic [ROM_DEPTH*CNT_W-1:0] C_TABLE =
    256'hFF78_FFB0_FF88_FFD0_FF50_FFA8_FFC8_FF70_FFE0_FF90_FFB8_FF60_FFD8_FFA0_FF80_FFC0,
  localparam int DEPTH = FIFO_BYTES / (DATA_W / 8),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [XFER_W-1:0] xfer_bytes,
  input  logic [LVL_W-1:0]  af_margin,
  input  logic              net_rd_en,
  output logic [DATA_W-1:0] net_rd_data,
  output logic              net_rd_valid,
  input  logic              net_wr_en,
  input  logic [DATA_W-1:0] net_wr_data,
  output logic              net_wr_ready,
  output logic [DATA_W-1:0] cons_data,
  output logic              cons_valid,
  output logic              prod_busy,
  output logic              prod_af,
  output logic              cons_af,
  output logic [STAT_W-1:0] prod_wr_count,
  output logic [STAT_W-1:0] cons_wr_count,
  output logic [STAT_W-1:0] stall_count
);
  localparam int BPW   = DATA_W / 8;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int IDX_W = $clog2(ROM_DEPTH);
  localparam logic [CNT_W-1:0]  CMAX   = '1;
  localparam logic [LVL_W-1:0]  FULL_L = LVL_W'(DEPTH);
  localparam logic [LVL_W:0]    DEP_W  = (LVL_W+1)'(DEPTH);
  localparam logic [XFER_W:0]   STEP_B = (XFER_W+1)'(BPW);

  function automatic logic [CNT_W-1:0] p_rom(input logic [IDX_W-1:0] i);
    return P_TABLE[i*CNT_W +: CNT_W];
  endfunction
  function automatic logic [CNT_W-1:0] c_rom(input logic [IDX_W-1:0] i);
    return C_TABLE[i*CNT_W +: CNT_W];
  endfunction
  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(ROM_DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  logic [DATA_W-1:0] p_mem [DEPTH];
  logic [DATA_W-1:0] c_mem [DEPTH];
  logic [PTR_W-1:0]  p_wr, p_rd, c_wr, c_rd;
  logic [LVL_W-1:0]  p_lvl, c_lvl;
  logic [CNT_W-1:0]  p_cnt, c_cnt;
  logic [IDX_W-1:0]  p_idx, c_idx;
  logic              p_run, p_hold, c_run, c_hold;
  logic [DATA_W-1:0] p_seq;
  logic [XFER_W:0]   p_sent, p_sent_nx;
  logic [XFER_W-1:0] xfer_q;

  logic p_full, c_full, p_due, c_due, p_push, p_pop, c_push, c_pop;

  assign p_full    = p_lvl == FULL_L;
  assign c_full    = c_lvl == FULL_L;
  assign p_due     = p_run && (p_hold || p_cnt == CMAX);
  assign c_due     = c_run && (c_hold || c_cnt == CMAX);
  assign p_push    = p_due && !p_full;
  assign p_pop     = net_rd_en && p_lvl != '0;
  assign c_push    = net_wr_en && !c_full;
  assign c_pop     = c_due && c_lvl != '0;
  assign p_sent_nx = p_sent + STEP_B;

  assign net_rd_data  = p_mem[p_rd];
  assign net_rd_valid = p_lvl != '0;
  assign net_wr_ready = !c_full;
  assign prod_busy    = p_run;
  assign prod_af      = ({1'b0, p_lvl} + {1'b0, af_margin}) >= DEP_W;
  assign cons_af      = ({1'b0, c_lvl} + {1'b0, af_margin}) >= DEP_W;

  always_ff @(posedge clk) begin
    if (p_push && !start) p_mem[p_wr] <= p_seq;
    if (c_push && !start) c_mem[c_wr] <= net_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_wr <= '0; p_rd <= '0; p_lvl <= '0; p_cnt <= '0; p_idx <= '0;
      p_run <= 1'b0; p_hold <= 1'b0; p_seq <= '0; p_sent <= '0; xfer_q <= '0;
      prod_wr_count <= '0; stall_count <= '0;
    end else if (start) begin
      p_wr <= '0; p_rd <= '0; p_lvl <= '0;
      p_cnt <= p_rom('0); p_idx <= nxt('0);
      p_run <= xfer_bytes != '0; p_hold <= 1'b0;
      p_seq <= '0; p_sent <= '0; xfer_q <= xfer_bytes;
      prod_wr_count <= '0; stall_count <= '0;
    end else begin
      p_lvl <= p_lvl + LVL_W'(p_push) - LVL_W'(p_pop);
      if (p_push) p_wr <= p_wr + 1'b1;
      if (p_pop)  p_rd <= p_rd + 1'b1;
      if (p_run && !p_hold) begin
        if (p_cnt == CMAX) begin
          p_cnt <= p_rom(p_idx);
          p_idx <= nxt(p_idx);
        end else begin
          p_cnt <= p_cnt + 1'b1;
        end
      end
      if (p_push) begin
        p_hold        <= 1'b0;
        p_seq         <= p_seq + 1'b1;
        p_sent        <= p_sent_nx;
        prod_wr_count <= prod_wr_count + 1'b1;
        if (p_sent_nx >= {1'b0, xfer_q}) p_run <= 1'b0;
      end else if (p_due) begin
        p_hold      <= 1'b1;
        stall_count <= stall_count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_wr <= '0; c_rd <= '0; c_lvl <= '0; c_cnt <= '0; c_idx <= '0;
      c_run <= 1'b0; c_hold <= 1'b0;
      cons_data <= '0; cons_valid <= 1'b0; cons_wr_count <= '0;
    end else if (start) begin
      c_wr <= '0; c_rd <= '0; c_lvl <= '0;
      c_cnt <= c_rom('0); c_idx <= nxt('0);
      c_run <= 1'b1; c_hold <= 1'b0;
      cons_valid <= 1'b0; cons_wr_count <= '0;
    end else begin
      c_lvl <= c_lvl + LVL_W'(c_push) - LVL_W'(c_pop);
      if (c_push) begin
        c_wr          <= c_wr + 1'b1;
        cons_wr_count <= cons_wr_count + 1'b1;
      end
      if (c_run && !c_hold) begin
        if (c_cnt == CMAX) begin
          c_cnt <= c_rom(c_idx);
          c_idx <= nxt(c_idx);
        end else begin
          c_cnt <= c_cnt + 1'b1;
        end
      end
      cons_valid <= c_pop;
      if (c_pop) begin
        cons_data <= c_mem[c_rd];
        c_rd      <= c_rd + 1'b1;
        c_hold    <= 1'b0;
      end else if (c_due) begin
        c_hold <= 1'b1;
      end
    end
  end

  // R8
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (prod_wr_count == $past(prod_wr_count) ||
                prod_wr_count == $past(prod_wr_count) + 1'b1));

  // R5
  stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !p_full) |=> $stable(stall_count));

  // R4
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !p_run) |=> $stable(prod_wr_count));

  // R6
  cons_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cons_valid |-> $past(c_lvl) != '0);

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_lvl <= FULL_L) && (c_lvl <= FULL_L));
endmodule

// File: tb/poisson_traffic_src_tb_top.sv
`timescale 1ns/1ps
module poisson_traffic_src_tb_top;
  localparam int DW = 32, FB = 32, RD = 4, CW = 4, XW = 12, SW = 32;
  localparam int LW = $clog2(FB / (DW / 8) + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [XW-1:0] xfer = '0;
  logic [LW-1:0] margin = '0;
  logic net_rd_en = 1'b0, net_wr_en = 1'b0;
  logic [DW-1:0] net_wr_data = '0;
  logic [DW-1:0] net_rd_data, cons_data;
  logic net_rd_valid, net_wr_ready, cons_valid, prod_busy, prod_af, cons_af;
  logic [SW-1:0] prod_wr_count, cons_wr_count, stall_count;

  // Producer intervals 4,2,6,1 cycles; consumer 12 cycles each.
  poisson_traffic_src #(
    .DATA_W(DW), .FIFO_BYTES(FB), .ROM_DEPTH(RD), .CNT_W(CW), .XFER_W(XW), .STAT_W(SW),
    .P_TABLE(16'hFAEC), .C_TABLE(16'h4444)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_bytes(xfer), .af_margin(margin),
    .net_rd_en(net_rd_en), .net_rd_data(net_rd_data), .net_rd_valid(net_rd_valid),
    .net_wr_en(net_wr_en), .net_wr_data(net_wr_data), .net_wr_ready(net_wr_ready),
    .cons_data(cons_data), .cons_valid(cons_valid), .prod_busy(prod_busy),
    .prod_af(prod_af), .cons_af(cons_af), .prod_wr_count(prod_wr_count),
    .cons_wr_count(cons_wr_count), .stall_count(stall_count)
  );

  always #2.5 clk = ~clk;

  int vecs = 0, errs = 0, cyc = 0;

  task automatic step();
    @(posedge clk); #1; cyc++;
  endtask

  task automatic go_to(int n);
    while (cyc < n) step();
  endtask

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic kick(int bytes, int m);
    xfer = XW'(bytes); margin = LW'(m); start = 1'b1;
    step();
    start = 1'b0; cyc = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 busy", prod_busy, 0);
    check("R1 rd_valid", net_rd_valid, 0);
    check("R1 cons_valid", cons_valid, 0);
    check("R1 wr_ready", net_wr_ready, 1);
    check("R1 counters", {prod_wr_count, cons_wr_count} | stall_count, 0);
    rst_n = 1'b1;
    repeat (20) step();
    check("R1 no production before start", prod_wr_count, 0);
  endtask

  task automatic t_timing();
    kick(1000, 2);
    go_to(3);  check("R2 before first event", prod_wr_count, 0);
    go_to(4);  check("R2 first event", prod_wr_count, 1);
    go_to(5);  check("R2 gap 2 pending", prod_wr_count, 1);
    go_to(6);  check("R2 second event", prod_wr_count, 2);
    go_to(11); check("R2 gap 6 pending", prod_wr_count, 2);
    go_to(12); check("R2 third event", prod_wr_count, 3);
    go_to(13); check("R2 gap 1", prod_wr_count, 4);
    go_to(16); check("R2 wrap pending", prod_wr_count, 4);
    go_to(17); check("R2 wrap to entry 0", prod_wr_count, 5);
    check("R9 af low at 5+2<8", prod_af, 0);
    go_to(19); check("R9 af high at 6+2>=8", prod_af, 1);
    check("R8 write count", prod_wr_count, 6);
    net_rd_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      check("R3 word order", net_rd_data, 64'(i));
      step();
    end
    net_rd_en = 1'b0;
    check("R3 next word after drain", net_rd_data, 6);
    check("R3 valid", net_rd_valid, 1);
  endtask

  task automatic t_size();
    kick(10, 0);
    check("R10 flush", net_rd_valid, 0);
    check("R10 count cleared", prod_wr_count, 0);
    go_to(40);
    check("R4 rounded-up size", prod_wr_count, 3);
    check("R4 busy dropped", prod_busy, 0);
    kick(0, 0);
    check("R4 zero size idle", prod_busy, 0);
    go_to(20);
    check("R4 zero size writes", prod_wr_count, 0);
    kick(8, 0);
    go_to(40);
    check("R4 exact size", prod_wr_count, 2);
  endtask

  task automatic t_stall();
    kick(1000, 0);
    go_to(26);
    check("R5 fill to depth", prod_wr_count, 8);
    check("R9 af at full margin 0", prod_af, 1);
    go_to(29); check("R5 no stall yet", stall_count, 0);
    go_to(30); check("R5 first stall", stall_count, 1);
    go_to(40);
    check("R5 stall per cycle", stall_count, 11);
    check("R5 held word not written", prod_wr_count, 8);
    net_rd_en = 1'b1;
    step();
    net_rd_en = 1'b0;
    check("R5 stall during pop edge", stall_count, 12);
    step();
    check("R5 held word written", prod_wr_count, 9);
    check("R5 stall stops", stall_count, 12);
    check("R5 head after pop", net_rd_data, 1);
  endtask

  task automatic t_cons();
    kick(0, 2);
    go_to(12); check("R6 empty at event", cons_valid, 0);
    go_to(13);
    for (int i = 0; i < 10; i++) begin
      net_wr_en = 1'b1;
      net_wr_data = 32'hC0DE_0000 + 32'(i);
      step();
      if (cyc == 14) check("R6 held read waits", cons_valid, 0);
      if (cyc == 15) begin
        check("R6 held read served", cons_valid, 1);
        check("R6 data", cons_data, 64'h0C0DE_0000);
      end
      if (cyc == 16) check("R6 one-cycle valid", cons_valid, 0);
      if (cyc == 22) begin
        check("R7 ready low when full", net_wr_ready, 0);
        check("R9 consumer af", cons_af, 1);
      end
    end
    net_wr_en = 1'b0;
    check("R7 R8 write ignored when full", cons_wr_count, 9);
    go_to(26); check("R6 paused counter", cons_valid, 0);
    go_to(27);
    check("R6 next event", cons_valid, 1);
    check("R6 next data", cons_data, 64'h0C0DE_0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_timing();
    t_size();
    t_stall();
    t_cons();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule